// File: doc/BRIEF.md
# Prioritised Single-Item DMA Channel Sequencer

This block sequences data movement for a small group of DMA channels, four by default. Peripherals raise a level request on their channel. Whenever the memory port is free, the sequencer picks one eligible channel and issues a single-item transfer to that channel's current address. After a successful transfer it advances that address by one. Software sets each channel's address and control bits through a write-only configuration port. Each write targets one channel, and a select bit chooses the address register or the control word.

If a transfer is refused because its address is invalid, the channel latches an error and stops. The error can be cleared only after software has written a new address to that channel. A channel can also be placed in event-gated mode. In that mode each peripheral event grants the channel exactly one item. An event that arrives while the channel's gated transfer is still in flight is reported as an overflow and is dropped.

Top module: `dma_seq`

## Requirements
- R1: When several eligible channels request in the same cycle, the channel with the lowest index is granted.
- R2: A granted transfer keeps `memReq` high with `memCh` and `memAddr` unchanged until `memAck` or `memErr` arrives. `memReq` is then low for at least one cycle, because arbitration happens only while the port is idle.
- R3: When a transfer completes with `memAck`, `chanDone` pulses for that channel in the same cycle. The channel's address then increases by one.
- R4: A transfer that ends with `memErr` sets that channel's bit in `errFlag` and leaves its address unchanged. The channel is not granted again while its error flag is set, and other channels are still served.
- R5: Writing 1 to control bit 3 (error clear) clears the error flag only if the channel's address has been written since the error. Otherwise the write has no effect on the flag. Writing the address alone does not clear the flag.
- R6: `irq` is high exactly while some channel has both its error flag and its error interrupt enable (control bit 1) set.
- R7: A channel whose control bit 2 (event mode) is set is never granted until a peripheral event has been received for it.
- R8: In event mode each event allows exactly one item. An event that arrives with no request pending is held until a request appears.
- R9: In event mode, an event that arrives while the channel's own transfer is in flight makes `evtOverflow` for that channel high for one cycle, starting the cycle after the event. That event grants no item.
- R10: A channel with control bit 0 (enable) clear is never granted. On a channel not in event mode, events have no effect and never cause an overflow.
- R11: After reset, `memReq`, `errFlag`, `irq`, `evtOverflow` and `chanDone` are all zero, and every channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgCh | input | CH_W | Channel addressed by the write |
| cfgSel | input | 1 | 0: address register, 1: control word |
| cfgData | input | ADDR_W | Write data. Control word: bit0 enable, bit1 error interrupt enable, bit2 event mode, bit3 error clear |
| periphReq | input | NUM_CH | Level transfer request per channel |
| periphEvt | input | NUM_CH | Single-cycle peripheral event per channel |
| memReq | output | 1 | Memory transfer request |
| memCh | output | CH_W | Channel owning the current transfer |
| memAddr | output | ADDR_W | Address of the current transfer |
| memAck | input | 1 | Memory accepted the transfer |
| memErr | input | 1 | Memory rejected the address |
| chanDone | output | NUM_CH | One-hot completion pulse |
| errFlag | output | NUM_CH | Latched transfer error per channel |
| irq | output | 1 | Error interrupt request |
| evtOverflow | output | NUM_CH | Event overflow pulse per channel |

## Verification
The assertions assume that the memory port never raises `memAck` and `memErr` together, and never raises either one while `memReq` is low. They also assume that software does not rewrite the address of the channel whose transfer is in flight. The bench memory model derives both responses from `memReq` and from a single address bound, so only one of them can be high, and a stall input holds both low. Every address and control write in the stimulus is made while the target channel is idle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  // Strobes sent from the sequencing control to the channel datapath.
  typedef struct packed {
    logic grant;   // a channel is being granted this cycle
    logic finish;  // current transfer completes with ack
    logic fault;   // current transfer completes with error
  } seqStrobe_t;

  typedef enum logic {
    CFG_ADDR = 1'b0,
    CFG_CTRL = 1'b1
  } cfgSel_t;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_IRQ_BIT = 1;
  localparam int CTRL_EVT_BIT = 2;
  localparam int CTRL_CLR_BIT = 3;

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] eligible,
  input  logic              memAck,
  input  logic              memErr,
  output seqStrobe_t        strobe,
  output logic [CH_W-1:0]   grantCh,
  output logic [CH_W-1:0]   curCh,
  output logic              busy
);

  logic pickValid;

  // Fixed priority: scanning downward leaves the lowest index as winner.
  always_comb begin
    pickValid = 1'b0;
    grantCh   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        pickValid = 1'b1;
        grantCh   = CH_W'(i);
      end
    end
  end

  always_comb begin
    strobe.grant  = !busy && pickValid;
    strobe.finish = busy && memAck && !memErr;
    strobe.fault  = busy && memErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      curCh <= '0;
    end else if (strobe.grant) begin
      busy  <= 1'b1;
      curCh <= grantCh;
    end else if (busy && (memAck || memErr)) begin
      busy  <= 1'b0;
    end
  end

  // R1: no eligible channel below the granted one
  for (genvar g = 0; g < NUM_CH; g++) begin : g_prioChk
    assert_lowest_wins_R1 : assert property (@(posedge clk) disable iff (!rstN)
      (strobe.grant && eligible[g]) |-> (grantCh <= CH_W'(g)));
  end

  // R2: the port is held until a response arrives
  assert_hold_until_resp_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memAck && !memErr) |=> (busy && $stable(curCh)));

  // R2: a response frees the port for one idle cycle
  assert_idle_after_resp_R2 : assert property (@(posedge clk) disable iff (!rstN)
    (busy && (memAck || memErr)) |=> !busy);

endmodule

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [NUM_CH-1:0] periphReq,
  input  logic [NUM_CH-1:0] periphEvt,
  input  seqStrobe_t        strobe,
  input  logic [CH_W-1:0]   grantCh,
  input  logic [CH_W-1:0]   curCh,
  input  logic              busy,
  output logic [NUM_CH-1:0] eligible,
  output logic [ADDR_W-1:0] memAddr,
  output logic [NUM_CH-1:0] chanDone,
  output logic [NUM_CH-1:0] errFlag,
  output logic              irq,
  output logic [NUM_CH-1:0] evtOverflow
);

  logic [ADDR_W-1:0] addrQ [NUM_CH];
  logic [NUM_CH-1:0] enQ, irqEnQ, evtModeQ, errQ, freshQ, creditQ, ovfQ;
  logic [NUM_CH-1:0] addrWr, ctrlWr, active, granted;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_decode
    assign addrWr[g]   = cfgWe && (cfgCh == CH_W'(g)) && (cfgSel == CFG_ADDR);
    assign ctrlWr[g]   = cfgWe && (cfgCh == CH_W'(g)) && (cfgSel == CFG_CTRL);
    assign active[g]   = busy && (curCh == CH_W'(g));
    assign granted[g]  = strobe.grant && (grantCh == CH_W'(g));
    assign chanDone[g] = strobe.finish && active[g];
    assign eligible[g] = enQ[g] && !errQ[g] && periphReq[g] &&
                         (!evtModeQ[g] || creditQ[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) addrQ[i] <= '0;
      enQ      <= '0;
      irqEnQ   <= '0;
      evtModeQ <= '0;
      errQ     <= '0;
      freshQ   <= '0;
      creditQ  <= '0;
      ovfQ     <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        ovfQ[i] <= periphEvt[i] && evtModeQ[i] && active[i];

        if (addrWr[i]) begin
          addrQ[i]  <= cfgData;
          freshQ[i] <= 1'b1;
        end else if (chanDone[i]) begin
          addrQ[i]  <= addrQ[i] + ADDR_W'(1);
        end

        if (ctrlWr[i]) begin
          enQ[i]      <= cfgData[CTRL_EN_BIT];
          irqEnQ[i]   <= cfgData[CTRL_IRQ_BIT];
          evtModeQ[i] <= cfgData[CTRL_EVT_BIT];
          if (cfgData[CTRL_CLR_BIT] && freshQ[i]) errQ[i] <= 1'b0;
        end

        if (strobe.fault && active[i]) begin
          errQ[i]   <= 1'b1;
          freshQ[i] <= 1'b0;
        end

        if (granted[i]) creditQ[i] <= 1'b0;
        if (periphEvt[i] && evtModeQ[i] && !active[i]) creditQ[i] <= 1'b1;
      end
    end
  end

  assign memAddr     = addrQ[curCh];
  assign errFlag     = errQ;
  assign irq         = |(errQ & irqEnQ);
  assign evtOverflow = ovfQ;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R3: completed item advances the address by one
    assert_addr_step_R3 : assert property (@(posedge clk) disable iff (!rstN)
      (chanDone[g] && !addrWr[g]) |=> (addrQ[g] == $past(addrQ[g]) + ADDR_W'(1)));
    // R4: a failed channel is never granted
    assert_err_no_grant_R4 : assert property (@(posedge clk) disable iff (!rstN)
      errQ[g] |-> !granted[g]);
    // R5: an error flag drops only through a clear write
    assert_clear_only_by_write_R5 : assert property (@(posedge clk) disable iff (!rstN)
      $fell(errQ[g]) |-> $past(ctrlWr[g] && cfgData[CTRL_CLR_BIT]));
    // R6: a new error on an enabled channel raises the interrupt
    assert_irq_on_err_R6 : assert property (@(posedge clk) disable iff (!rstN)
      ($rose(errQ[g]) && irqEnQ[g]) |-> irq);
    // R7: event-gated grants need a stored event
    assert_evt_gate_R7 : assert property (@(posedge clk) disable iff (!rstN)
      (granted[g] && evtModeQ[g]) |-> creditQ[g]);
    // R9: overflow follows an event during the channel's own transfer
    assert_ovf_source_R9 : assert property (@(posedge clk) disable iff (!rstN)
      evtOverflow[g] |-> $past(active[g] && periphEvt[g]));
  end

  // R3: completion pulse is one-hot or idle
  assert_done_onehot_R3 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanDone));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [NUM_CH-1:0] periphReq,
  input  logic [NUM_CH-1:0] periphEvt,
  output logic              memReq,
  output logic [CH_W-1:0]   memCh,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic              memErr,
  output logic [NUM_CH-1:0] chanDone,
  output logic [NUM_CH-1:0] errFlag,
  output logic              irq,
  output logic [NUM_CH-1:0] evtOverflow
);

  seqStrobe_t        strobe;
  logic [NUM_CH-1:0] eligible;
  logic [CH_W-1:0]   grantCh, curCh;
  logic              busy;

  dma_seq_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .memAck(memAck), .memErr(memErr),
    .strobe(strobe), .grantCh(grantCh), .curCh(curCh), .busy(busy)
  );

  dma_seq_dp #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgSel(cfgSel),
    .cfgData(cfgData), .periphReq(periphReq), .periphEvt(periphEvt),
    .strobe(strobe), .grantCh(grantCh), .curCh(curCh), .busy(busy),
    .eligible(eligible), .memAddr(memAddr), .chanDone(chanDone),
    .errFlag(errFlag), .irq(irq), .evtOverflow(evtOverflow)
  );

  assign memReq = busy;
  assign memCh  = curCh;

endmodule

// File: tb/dma_seq_tb.sv
module dma_seq_tb;

  localparam int NUM_CH = 4;
  localparam int ADDR_W = 16;
  localparam int CH_W   = 2;
  localparam logic [ADDR_W-1:0] LIMIT = 16'h0100;
  // {request mask[7:4], expected winner[1:0]}
  localparam logic [7:0] VEC [8] = '{8'hF0, 8'hE1, 8'hC2, 8'h83,
                                     8'hA1, 8'h61, 8'h50, 8'h90};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [CH_W-1:0] cfgCh = '0;
  logic cfgSel = 1'b0;
  logic [ADDR_W-1:0] cfgData = '0;
  logic [NUM_CH-1:0] periphReq = '0, periphEvt = '0;
  logic memReq, memAck, memErr, irq;
  logic [CH_W-1:0] memCh;
  logic [ADDR_W-1:0] memAddr;
  logic [NUM_CH-1:0] chanDone, errFlag, evtOverflow;
  logic stall = 1'b0;

  int checks = 0;
  int errors = 0;
  int xferCnt [NUM_CH] = '{0, 0, 0, 0};
  int addrM [NUM_CH];

  always #10 clk = ~clk;

  dma_seq #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgSel(cfgSel),
    .cfgData(cfgData), .periphReq(periphReq), .periphEvt(periphEvt),
    .memReq(memReq), .memCh(memCh), .memAddr(memAddr), .memAck(memAck),
    .memErr(memErr), .chanDone(chanDone), .errFlag(errFlag), .irq(irq),
    .evtOverflow(evtOverflow)
  );

  // Memory model: accepts addresses below LIMIT, rejects the rest.
  assign memAck = memReq && !stall && (memAddr < LIMIT);
  assign memErr = memReq && !stall && (memAddr >= LIMIT);

  always @(posedge clk) if (memReq && memAck) xferCnt[memCh] = xferCnt[memCh] + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input int ch, input bit sel, input int data);
    @(negedge clk);
    cfgWe = 1'b1; cfgCh = CH_W'(ch); cfgSel = sel; cfgData = ADDR_W'(data);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitReq(output bit found);
    found = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (memReq) begin found = 1'b1; break; end
    end
  endtask

  task automatic pulseEvt(input int ch);
    periphEvt = NUM_CH'(1 << ch);
    @(negedge clk);
    periphEvt = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit found;
    bit quiet;
    int base;
    logic [ADDR_W-1:0] a0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(!memReq && errFlag == 0 && !irq && evtOverflow == 0 && chanDone == 0,
          "R11 reset outputs", {memReq, errFlag, irq, evtOverflow}, 0);
    periphReq = 4'hF;
    repeat (3) @(negedge clk);
    check(!memReq, "R11 channels disabled after reset", memReq, 0);
    periphReq = '0;

    for (int i = 0; i < NUM_CH; i++) begin
      addrM[i] = i * 16;
      cfgWrite(i, 1'b0, addrM[i]);
      cfgWrite(i, 1'b1, 1);
    end

    // R1 / R3: priority table
    for (int v = 0; v < 8; v++) begin
      int expCh;
      expCh = int'(VEC[v][1:0]);
      periphReq = VEC[v][7:4];
      waitReq(found);
      check(found && memCh == CH_W'(expCh), "R1 lowest index wins", memCh, expCh);
      check(memAddr == ADDR_W'(addrM[expCh]), "R3 address of item", memAddr, addrM[expCh]);
      check(chanDone == NUM_CH'(1 << expCh), "R3 done pulse", chanDone, 1 << expCh);
      periphReq = '0;
      addrM[expCh]++;
      @(negedge clk);
      check(!memReq, "R2 port idle after ack", memReq, 0);
    end

    // R2: hold under stall
    stall = 1'b1;
    periphReq = 4'b0100;
    waitReq(found);
    a0 = memAddr;
    quiet = 1'b1;
    repeat (3) begin
      @(negedge clk);
      if (!memReq || memAddr != a0 || memCh != 2'd2) quiet = 1'b0;
    end
    check(quiet && chanDone == 0, "R2 request held while stalled", {memReq, memAddr}, {1'b1, a0});
    stall = 1'b0;
    periphReq = '0;
    addrM[2]++;
    @(negedge clk);

    // R2: idle gap between back-to-back items
    periphReq = 4'b0001;
    waitReq(found);
    addrM[0]++;
    @(negedge clk);
    check(!memReq, "R2 gap cycle", memReq, 0);
    @(negedge clk);
    check(memReq && memAddr == ADDR_W'(addrM[0]), "R3 next item address", memAddr, addrM[0]);
    periphReq = '0;
    addrM[0]++;
    @(negedge clk);

    // R10: disabled channel
    cfgWrite(3, 1'b1, 0);
    periphReq = 4'b1000;
    quiet = 1'b1;
    repeat (5) begin @(negedge clk); if (memReq) quiet = 1'b0; end
    check(quiet, "R10 disabled channel not granted", !quiet, 0);
    periphReq = '0;
    cfgWrite(3, 1'b1, 1);

    // R4: address error
    cfgWrite(1, 1'b0, 16'h01F0);
    cfgWrite(1, 1'b1, 4'b0011);
    periphReq = 4'b0010;
    waitReq(found);
    check(found && memErr && memCh == 2'd1, "R4 error response", memErr, 1);
    @(negedge clk);
    check(errFlag == 4'b0010, "R4 error flag", errFlag, 4'b0010);
    check(irq, "R6 irq with enable", irq, 1);
    periphReq = 4'b0110;
    waitReq(found);
    check(found && memCh == 2'd2, "R4 other channels still served", memCh, 2);
    periphReq = 4'b0010;
    addrM[2]++;
    quiet = 1'b1;
    repeat (5) begin @(negedge clk); if (memReq) quiet = 1'b0; end
    check(quiet, "R4 stopped channel not granted", !quiet, 0);
    periphReq = '0;

    // R5: clear rules
    cfgWrite(1, 1'b1, 4'b1011);
    check(errFlag[1] && irq, "R5 clear without new address ignored", errFlag[1], 1);
    cfgWrite(1, 1'b0, 16'h0040);
    check(errFlag[1], "R5 address write alone keeps flag", errFlag[1], 1);
    cfgWrite(1, 1'b1, 4'b1011);
    check(!errFlag[1] && !irq, "R5 clear after new address", {errFlag[1], irq}, 0);
    periphReq = 4'b0010;
    waitReq(found);
    check(found && memCh == 2'd1 && memAddr == 16'h0040, "R5 restart at new address", memAddr, 16'h0040);
    periphReq = '0;
    @(negedge clk);

    // R6: error without interrupt enable
    cfgWrite(3, 1'b0, 16'h0300);
    cfgWrite(3, 1'b1, 1);
    periphReq = 4'b1000;
    waitReq(found);
    periphReq = '0;
    @(negedge clk);
    check(errFlag == 4'b1000 && !irq, "R6 no irq when disabled", {errFlag, irq}, 5'b10000);
    cfgWrite(3, 1'b1, 3);
    check(irq, "R6 irq follows enable", irq, 1);
    cfgWrite(3, 1'b0, 16'h0030);
    cfgWrite(3, 1'b1, 4'b1001);
    check(!irq && errFlag == 0, "R6 irq drops with clear", {errFlag, irq}, 0);

    // R7 / R8: event gating
    cfgWrite(2, 1'b1, 4'b0101);
    base = xferCnt[2];
    periphReq = 4'b0100;
    quiet = 1'b1;
    repeat (6) begin @(negedge clk); if (memReq) quiet = 1'b0; end
    check(quiet && xferCnt[2] == base, "R7 blocked without event", xferCnt[2], base);
    pulseEvt(2);
    waitReq(found);
    check(found && memCh == 2'd2 && memAddr == ADDR_W'(addrM[2]), "R7 event releases one item", memAddr, addrM[2]);
    addrM[2]++;
    repeat (6) @(negedge clk);
    check(xferCnt[2] == base + 1, "R8 one item per event", xferCnt[2], base + 1);
    periphReq = '0;
    pulseEvt(2);
    quiet = 1'b1;
    repeat (3) begin @(negedge clk); if (memReq) quiet = 1'b0; end
    check(quiet, "R8 stored event waits for request", !quiet, 0);
    periphReq = 4'b0100;
    waitReq(found);
    check(found && memCh == 2'd2, "R8 stored event used", memCh, 2);
    periphReq = '0;
    addrM[2]++;
    @(negedge clk);
    check(xferCnt[2] == base + 2, "R8 item count", xferCnt[2], base + 2);

    // R9: overflow while busy
    stall = 1'b1;
    periphReq = 4'b0100;
    pulseEvt(2);
    waitReq(found);
    pulseEvt(2);
    check(evtOverflow == 4'b0100, "R9 overflow pulse", evtOverflow, 4'b0100);
    @(negedge clk);
    check(evtOverflow == 0, "R9 overflow one cycle", evtOverflow, 0);
    stall = 1'b0;
    addrM[2]++;
    repeat (6) @(negedge clk);
    check(xferCnt[2] == base + 3 && !memReq, "R9 overflowed event dropped", xferCnt[2], base + 3);
    periphReq = '0;

    // R10: events ignored on a normal channel
    stall = 1'b1;
    periphReq = 4'b0001;
    waitReq(found);
    pulseEvt(0);
    check(evtOverflow == 0, "R10 no overflow in normal mode", evtOverflow, 0);
    stall = 1'b0;
    periphReq = '0;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule